// File: doc/BRIEF.md
# Latched Framer Alarm Status Register

This block is the latched alarm register of a DS3/E3 framer. It sits beside the live alarm detectors and the frame aligner. Six live alarm levels are watched for any transition. A rise and a fall both leave a sticky bit set. A frame-alignment tracker sets one further sticky bit when sync is regained at a position that differs from the position the framer held before.

Host software reads the register through a small synchronous register port. It clears any bit by writing 1 to it. An active-high level interrupt is raised while a latched bit is set and both its own enable and the block enable are on.

Top module: `frm_alarm_latch`

## Requirements
- R1: After synchronous reset, every latched bit reads 0 and `irq` is 0.
- R2: Bit layout: bit 0 loss of signal, bit 1 out of frame, bit 2 AIS, bit 3 remote alarm, bit 4 DS3 idle, bit 5 severely errored frame. Bit 6 always reads 0. Bit 7 is the alignment-change latch.
- R3: Any transition of `alm_live[i]` (0 to 1 or 1 to 0) sets bit i at the clock edge that first samples the new level. The bit is readable from the next cycle.
- R4: A write with `reg_we`=1 and `reg_addr`=0x19 clears every latched bit whose position holds 1 in `reg_wdata`.
- R5: Positions written with 0 keep their latched value.
- R6: `irq` is the OR, over all bits, of latched bit AND `bit_en` bit, gated by `blk_en`. It is combinational from the registered state.
- R7: `irq` falls in the same cycle that `blk_en` or the relevant `bit_en` bit drops, and in the cycle after the last enabled bit is cleared.
- R8: Bit 7 never sets before the first sync has been achieved. It sets when `sync_ok` rises after a loss and `sync_pos` differs from the position captured at the previous acquisition.
- R9: Bit 7 does not set on reacquisition at the same position, nor on position changes while sync is held. Once cleared, it sets again only after a loss and a reacquisition at a new position.
- R10: When a set condition and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R11: Writes to any address other than 0x19 change nothing. `reg_rdata` is 0 whenever `reg_addr` is not 0x19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data (1 clears the bit) |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data, combinational from address |
| alm_live | input | 6 | Live alarm levels, bit order as in R2 |
| sync_ok | input | 1 | Frame sync achieved |
| sync_pos | input | POS_W | Alignment position while in sync |
| bit_en | input | 8 | Per-bit interrupt enable |
| blk_en | input | 1 | Block-level interrupt enable |
| irq | output | 1 | Level interrupt request |

## Verification
A stale previous-value copy shows up as a bit that sets without a transition, or misses one. It appears in the read data one cycle after the edge that sampled the change. A wrong alignment state or stored position shows as bit 7 setting on a same-position reacquisition, or before the first sync. It can also show as bit 7 failing to set at a new position. These faults appear only at the reacquisition edge, so the stimulus repeatedly drops and regains sync over a small set of positions. The interrupt is compared every cycle, so a gating fault shows in the same cycle as the enable change.

// File: rtl/fas_pkg.sv
package fas_pkg;

    localparam int NUM_ALM  = 6;
    localparam int STAT_W   = 8;
    localparam int BIT_RSVD = 6;
    localparam int BIT_COFA = 7;

    typedef enum logic [1:0] {
        ALN_NEVER  = 2'd0,
        ALN_LOCKED = 2'd1,
        ALN_LOST   = 2'd2
    } aln_state_t;

    typedef struct packed {
        logic cofa;
        logic rsvd;
        logic sef;
        logic idle;
        logic rai;
        logic ais;
        logic oof;
        logic los;
    } stat_t;

    function automatic stat_t pack_stat(input logic cofa, input logic [NUM_ALM-1:0] alm);
        stat_t s;
        s.cofa = cofa;
        s.rsvd = 1'b0;
        s.sef  = alm[5];
        s.idle = alm[4];
        s.rai  = alm[3];
        s.ais  = alm[2];
        s.oof  = alm[1];
        s.los  = alm[0];
        return s;
    endfunction

endpackage

// File: rtl/fas_chg_latch.sv
module fas_chg_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] live,
    input  logic [N-1:0] clr,
    output logic [N-1:0] lat
);

    logic [N-1:0] prev_q;
    logic [N-1:0] lat_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic chg;
        assign chg = live[i] ^ prev_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= 1'b0;
                lat_q[i]  <= 1'b0;
            end else begin
                prev_q[i] <= live[i];
                // set has priority over clear
                lat_q[i]  <= chg | (lat_q[i] & ~clr[i]);
            end
        end

        // R3: a transition on the live level leaves the bit set
        assert_change_sets_R3: assert property (@(posedge clk) disable iff (rst)
            (live[i] != prev_q[i]) |=> lat_q[i]);
        // R4: a clear with no transition empties the bit
        assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && (live[i] == prev_q[i])) |=> !lat_q[i]);
        // R5: without a clear the bit holds
        assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (lat_q[i] && !clr[i]) |=> lat_q[i]);
    end

    assign lat = lat_q;

endmodule

// File: rtl/fas_align_track.sv
module fas_align_track
    import fas_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_ok,
    input  logic [POS_W-1:0] sync_pos,
    input  logic             clr,
    output logic             cofa
);

    aln_state_t       st_q;
    logic [POS_W-1:0] pos_q;
    logic             cofa_q;
    logic             reacq_new;

    assign reacq_new = (st_q == ALN_LOST) && sync_ok && (sync_pos != pos_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ALN_NEVER;
            pos_q  <= '0;
            cofa_q <= 1'b0;
        end else begin
            cofa_q <= reacq_new | (cofa_q & ~clr);
            unique case (st_q)
                ALN_NEVER: if (sync_ok) begin
                    st_q  <= ALN_LOCKED;
                    pos_q <= sync_pos;
                end
                ALN_LOCKED: if (!sync_ok) st_q <= ALN_LOST;
                ALN_LOST: if (sync_ok) begin
                    st_q  <= ALN_LOCKED;
                    pos_q <= sync_pos;
                end
                default: st_q <= ALN_NEVER;
            endcase
        end
    end

    assign cofa = cofa_q;

    // R8: never set before first acquisition
    assert_no_set_unsynced_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ALN_NEVER) |-> !cofa_q);
    // R9: same-position reacquisition leaves a clear bit clear
    assert_same_pos_R9: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ALN_LOST) && sync_ok && (sync_pos == pos_q) && !cofa_q) |=> !cofa_q);
    // R9: while locked, a cleared bit stays clear
    assert_locked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ALN_LOCKED) && !cofa_q) |=> !cofa_q);
    // R10: set beats clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ALN_LOST) && sync_ok && (sync_pos != pos_q)) |=> cofa_q);

endmodule

// File: rtl/fas_irq_gate.sv
module fas_irq_gate #(
    parameter int W = 8
) (
    input  logic [W-1:0] stat,
    input  logic [W-1:0] bit_en,
    input  logic         blk_en,
    output logic         irq
);

    logic [W-1:0] req;

    for (genvar i = 0; i < W; i++) begin : g_req
        assign req[i] = stat[i] & bit_en[i];
    end

    always_comb begin
        irq = blk_en & (|req);
    end

endmodule

// File: rtl/frm_alarm_latch.sv
module frm_alarm_latch
    import fas_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h19,
    parameter int              POS_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic [NUM_ALM-1:0] alm_live,
    input  logic              sync_ok,
    input  logic [POS_W-1:0]  sync_pos,
    input  logic [STAT_W-1:0] bit_en,
    input  logic              blk_en,
    output logic              irq
);

    logic              sel;
    logic [STAT_W-1:0] clr_vec;
    logic [NUM_ALM-1:0] alm_lat;
    logic              cofa_lat;
    stat_t             stat;

    assign sel     = (reg_addr == REG_ADDR);
    assign clr_vec = (reg_we && sel) ? reg_wdata : '0;

    fas_chg_latch #(.N(NUM_ALM)) u_chg (
        .clk  (clk),
        .rst  (rst),
        .live (alm_live),
        .clr  (clr_vec[NUM_ALM-1:0]),
        .lat  (alm_lat)
    );

    fas_align_track #(.POS_W(POS_W)) u_aln (
        .clk      (clk),
        .rst      (rst),
        .sync_ok  (sync_ok),
        .sync_pos (sync_pos),
        .clr      (clr_vec[BIT_COFA]),
        .cofa     (cofa_lat)
    );

    assign stat      = pack_stat(cofa_lat, alm_lat);
    assign reg_rdata = sel ? stat : '0;

    fas_irq_gate #(.W(STAT_W)) u_irq (
        .stat   (stat),
        .bit_en (bit_en),
        .blk_en (blk_en),
        .irq    (irq)
    );

    // R2: reserved position reads zero
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[BIT_RSVD] == 1'b0);
    // R7: block enable off silences the request
    assert_blk_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !blk_en |-> !irq);
    // R11: other addresses read zero
    assert_miss_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (reg_rdata == '0));
    // R1: state right after reset is empty
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (stat == '0));

endmodule

// File: tb/frm_alarm_latch_tb.sv
`timescale 1ns/1ps
module frm_alarm_latch_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic [5:0] alm_live;
    logic       sync_ok;
    logic [3:0] sync_pos;
    logic [7:0] bit_en;
    logic       blk_en;
    logic       irq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] m_lat;
    logic [5:0] m_prev;
    int         m_st;
    logic [3:0] m_pos;

    always #4 clk = ~clk;

    frm_alarm_latch u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .alm_live(alm_live),
        .sync_ok(sync_ok), .sync_pos(sync_pos), .bit_en(bit_en),
        .blk_en(blk_en), .irq(irq)
    );

    function automatic logic exp_irq(input logic [7:0] lat, input logic [7:0] en, input logic blk);
        return blk && ((lat & en) != 8'h00);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] addr, input logic [7:0] lat);
        return (addr == 8'h19) ? lat : 8'h00;
    endfunction

    task automatic model_update();
        logic [7:0] clr;
        logic [7:0] set;
        logic       cset;
        if (rst) begin
            m_lat = 8'h00; m_prev = 6'h00; m_st = 0; m_pos = 4'h0;
            return;
        end
        clr  = (reg_we && reg_addr == 8'h19) ? reg_wdata : 8'h00;
        cset = (m_st == 2) && sync_ok && (sync_pos != m_pos);
        set  = {cset, 1'b0, alm_live ^ m_prev};
        m_lat = set | (m_lat & ~clr);
        m_lat[6] = 1'b0;
        m_prev = alm_live;
        if (m_st == 0 && sync_ok) begin m_st = 1; m_pos = sync_pos; end
        else if (m_st == 1 && !sync_ok) m_st = 2;
        else if (m_st == 2 && sync_ok) begin m_st = 1; m_pos = sync_pos; end
    endtask

    task automatic check_outputs();
        logic [7:0] erd;
        logic       eirq;
        erd  = exp_rd(reg_addr, m_lat);
        eirq = exp_irq(m_lat, bit_en, blk_en);
        checks++;
        if (reg_rdata !== erd) begin
            errors++;
            $display("FAIL %s rdata actual=%02h expected=%02h", cur_req, reg_rdata, erd);
        end
        checks++;
        if (irq !== eirq) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b", cur_req, irq, eirq);
        end
    endtask

    // inputs already driven (at negedge); advance one edge and compare
    task automatic step();
        model_update();
        @(posedge clk);
        #1;
        check_outputs();
        @(negedge clk);
    endtask

    task automatic idle_in();
        reg_we = 1'b0; reg_wdata = 8'h00; reg_addr = 8'h19;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        idle_in();
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL %s watchdog actual=hung expected=done", cur_req);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; idle_in(); alm_live = '0; sync_ok = 0; sync_pos = 0;
        bit_en = 8'hFF; blk_en = 1'b1;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        cur_req = "R1";
        step();

        // R3 rising and falling both latch; R4 clear
        cur_req = "R3"; alm_live[0] = 1; step(); step();
        cur_req = "R4"; wr(8'h19, 8'h01);
        cur_req = "R3"; alm_live[0] = 0; step();
        alm_live[5] = 1; step();
        // R5 writing zeros keeps bits
        cur_req = "R5"; wr(8'h19, 8'h00); wr(8'h19, 8'h1E);
        // R10 set beats clear
        cur_req = "R10"; alm_live[2] = 1; reg_we = 1; reg_wdata = 8'h04; step(); idle_in(); step();
        // R6 / R7 interrupt gating
        cur_req = "R6"; bit_en = 8'h04; step();
        cur_req = "R7"; blk_en = 0; step(); blk_en = 1; bit_en = 8'h02; step();
        bit_en = 8'h04; step(); wr(8'h19, 8'h04); step();
        // R11 other addresses
        cur_req = "R11"; wr(8'h18, 8'hFF); reg_addr = 8'h18; step(); idle_in(); step();
        wr(8'h19, 8'hFF);
        // R8 / R9 alignment tracking
        cur_req = "R8"; sync_ok = 1; sync_pos = 3; step(); step();
        sync_ok = 0; step();
        cur_req = "R9"; sync_ok = 1; step();
        sync_ok = 0; sync_pos = 5; step();
        cur_req = "R8"; sync_ok = 1; step(); step();
        cur_req = "R9"; wr(8'h19, 8'h80); sync_pos = 9; step();
        sync_ok = 0; sync_pos = 5; step(); sync_ok = 1; step();
        sync_ok = 0; sync_pos = 2; step();
        cur_req = "R8"; sync_ok = 1; step();
        cur_req = "R10"; sync_ok = 0; sync_pos = 7; step();
        sync_ok = 1; reg_we = 1; reg_wdata = 8'h80; step(); idle_in(); step();
        cur_req = "R2"; step();

        // constrained random
        cur_req = "R3";
        for (int n = 0; n < 3000; n++) begin
            for (int b = 0; b < 6; b++) if ($urandom % 8 == 0) alm_live[b] = ~alm_live[b];
            if ($urandom % 6 == 0) sync_ok = ~sync_ok;
            if (!sync_ok) sync_pos = 4'($urandom % 4);
            reg_we    = ($urandom % 3 == 0);
            reg_wdata = 8'($urandom);
            reg_addr  = ($urandom % 4 != 0) ? 8'h19 : 8'($urandom);
            if ($urandom % 16 == 0) bit_en = 8'($urandom);
            blk_en = ($urandom % 8 != 0);
            case (n % 4)
                0: cur_req = "R3";
                1: cur_req = "R4";
                2: cur_req = "R6";
                default: cur_req = "R8";
            endcase
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule